// File: doc/BRIEF.md
# Saturating Rounded Multiply-High-Add

This unit is a SIMD fixed-point datapath that works on 128-bit vectors holding eight signed 16-bit lanes. In every lane it multiplies two operands and adds a rounding bias. It scales the product back to Q15 precision and adds the sign-extended lane of a third operand. The sum is then clipped to the signed 16-bit range. Lanes never interact. The only state they share is one sticky flag, which records that at least one lane of some vector was clipped.

The datapath has two pipeline stages. The first stage registers the rounded, scaled products together with the third operand. The second stage registers the saturated sums and updates the flag. A new vector can enter on every cycle. The flag stays set until software-style control logic pulses the clear input. A clip that arrives in the same cycle as a clear takes priority over the clear.

Top module: `vec_mhradd_sat`

## Requirements
- R1: Lane i of every 128-bit operand and of the result occupies bits [16i+15:16i]. Each lane is computed only from the same lane of the three operands.
- R2: A lane result equals sat16(((a*b + 0x4000) >>> 15) + c). Here a, b and c are the signed 16-bit lanes of opnd_a, opnd_b and opnd_c, and the shift is arithmetic.
- R3: A sum above 32767 gives 0x7FFF, and a sum below -32768 gives 0x8000. Any other sum passes through unchanged.
- R4: out_valid follows in_valid exactly two cycles later, and result holds the matching vector in that cycle. Vectors presented on consecutive cycles come out on consecutive cycles.
- R5: When any lane of a valid vector clips, sat_sticky reads 1 in the same cycle that out_valid shows that vector.
- R6: sat_sticky stays 1 until sat_clr is high at a clock edge. It reads 0 after that edge unless R7 applies.
- R7: If a clipping vector reaches the output at the same edge where sat_clr is high, sat_sticky stays 1.
- R8: a = 0x8000, b = 0x8000, c = 0x7FFF gives 0x7FFF and sets sat_sticky.
- R9: After reset, out_valid, result and sat_sticky are all 0.
- R10: Operands presented with in_valid low do not change result and do not set sat_sticky.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands are valid this cycle |
| opnd_a | input | 128 | Multiplicand lanes |
| opnd_b | input | 128 | Multiplier lanes |
| opnd_c | input | 128 | Addend lanes |
| sat_clr | input | 1 | Clear strobe for the sticky flag |
| out_valid | output | 1 | Result is valid |
| result | output | 128 | Saturated lane results |
| sat_sticky | output | 1 | Sticky clip flag |

## Verification
The sweep sends every combination of eight boundary lane values through the three operands. The combinations are spread across all lanes, so the product of two most-negative values is covered in each lane. A design that shifts before rounding gives results that are one too low. A design that keeps the scaled product at 16 bits wraps 0x8000*0x8000 to a negative value instead of clipping it. A design that saturates in the wrong direction, or leaks carries between lanes, produces mismatches against the bench's arithmetic model. Separate scenarios strike a clear and a clip at the same edge, present operands with in_valid low, and stream vectors back to back. These catch a clear that wins over a clip, stray flag setting, and pipeline slots that drop or duplicate vectors.

// File: rtl/smrha_pkg.sv
package smrha_pkg;
    parameter int LANE_W = 16;
    parameter int LANES  = 8;
    localparam int VEC_W = LANE_W * LANES;

    typedef enum logic [1:0] {
        FLAG_KEEP  = 2'd0,
        FLAG_SET   = 2'd1,
        FLAG_CLEAR = 2'd2
    } flag_act_e;

    // Width of a lane product kept with one guard bit
    function automatic int prod_width(input int lw);
        return 2 * lw + 1;
    endfunction
endpackage

// File: rtl/smrha_mul_stage.sv
module smrha_mul_stage #(
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld,
    input  logic [LW-1:0] a,
    input  logic [LW-1:0] b,
    input  logic [LW-1:0] c,
    output logic [LW:0]   scaled,
    output logic [LW-1:0] addend
);
    localparam int PW    = smrha_pkg::prod_width(LW);
    localparam int SHIFT = LW - 1;
    localparam logic signed [PW-1:0] RND = PW'(1) <<< (LW - 2);

    logic signed [PW-1:0] a_x, b_x, prod, biased, shifted;

    always_comb begin
        a_x     = {{(PW-LW){a[LW-1]}}, a};
        b_x     = {{(PW-LW){b[LW-1]}}, b};
        prod    = a_x * b_x;
        biased  = prod + RND;
        shifted = biased >>> SHIFT;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            scaled <= '0;
            addend <= '0;
        end else if (ld) begin
            scaled <= shifted[LW:0];
            addend <= c;
        end
    end
endmodule

// File: rtl/smrha_acc_stage.sv
module smrha_acc_stage #(
    parameter int LW = 16
) (
    input  logic [LW:0]   scaled,
    input  logic [LW-1:0] addend,
    output logic [LW-1:0] res,
    output logic          clip
);
    localparam int SW = LW + 2;
    localparam logic [LW-1:0] POS_MAX = {1'b0, {(LW-1){1'b1}}};
    localparam logic [LW-1:0] NEG_MIN = {1'b1, {(LW-1){1'b0}}};

    logic [SW-1:0] sum;
    logic          top_agree;

    always_comb begin
        sum       = {scaled[LW], scaled} + {{2{addend[LW-1]}}, addend};
        top_agree = (sum[SW-1:LW-1] == '0) || (sum[SW-1:LW-1] == '1);
        clip      = !top_agree;
        if (top_agree)         res = sum[LW-1:0];
        else if (sum[SW-1])    res = NEG_MIN;
        else                   res = POS_MAX;
    end
endmodule

// File: rtl/smrha_sticky.sv
module smrha_sticky (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic flag
);
    import smrha_pkg::*;

    flag_act_e act;

    always_comb begin
        if (set)      act = FLAG_SET;
        else if (clr) act = FLAG_CLEAR;
        else          act = FLAG_KEEP;
    end

    always_ff @(posedge clk) begin
        if (rst) flag <= 1'b0;
        else begin
            case (act)
                FLAG_SET:   flag <= 1'b1;
                FLAG_CLEAR: flag <= 1'b0;
                default:    flag <= flag;
            endcase
        end
    end
endmodule

// File: rtl/vec_mhradd_sat.sv
module vec_mhradd_sat #(
    parameter int LANE_W = smrha_pkg::LANE_W,
    parameter int LANES  = smrha_pkg::LANES,
    localparam int VW    = LANE_W * LANES
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [VW-1:0] opnd_a,
    input  logic [VW-1:0] opnd_b,
    input  logic [VW-1:0] opnd_c,
    input  logic          sat_clr,
    output logic          out_valid,
    output logic [VW-1:0] result,
    output logic          sat_sticky
);
    logic                s1_valid;
    logic [LANE_W:0]     s1_scaled [LANES];
    logic [LANE_W-1:0]   s1_addend [LANES];
    logic [VW-1:0]       s2_res;
    logic [LANES-1:0]    s2_clip;
    logic                sat_any;

    always_ff @(posedge clk) begin
        if (rst) s1_valid <= 1'b0;
        else     s1_valid <= in_valid;
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        smrha_mul_stage #(.LW(LANE_W)) u_mul (
            .clk    (clk),
            .rst    (rst),
            .ld     (in_valid),
            .a      (opnd_a[i*LANE_W +: LANE_W]),
            .b      (opnd_b[i*LANE_W +: LANE_W]),
            .c      (opnd_c[i*LANE_W +: LANE_W]),
            .scaled (s1_scaled[i]),
            .addend (s1_addend[i])
        );
        smrha_acc_stage #(.LW(LANE_W)) u_acc (
            .scaled (s1_scaled[i]),
            .addend (s1_addend[i]),
            .res    (s2_res[i*LANE_W +: LANE_W]),
            .clip   (s2_clip[i])
        );
    end

    assign sat_any = s1_valid && (|s2_clip);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid) result <= s2_res;
        end
    end

    smrha_sticky u_flag (
        .clk  (clk),
        .rst  (rst),
        .set  (sat_any),
        .clr  (sat_clr),
        .flag (sat_sticky)
    );
endmodule

// File: rtl/smrha_chk.sv
module smrha_chk #(
    parameter int VW = 128
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic          sat_clr,
    input logic          out_valid,
    input logic [VW-1:0] result,
    input logic          sat_sticky,
    input logic          s1_valid,
    input logic          sat_any
);
    logic [1:0] cyc;
    always_ff @(posedge clk) begin
        if (rst)           cyc <= 2'd0;
        else if (cyc != 3) cyc <= cyc + 2'd1;
    end

    p_reset_r9: assert property (@(posedge clk) rst |=> (!out_valid && !sat_sticky && result == '0));
    p_lag_r4: assert property (@(posedge clk) disable iff (rst) (cyc >= 2) |-> (out_valid == $past(in_valid, 2)));
    p_rise_r5: assert property (@(posedge clk) disable iff (rst) $rose(sat_sticky) |-> out_valid);
    p_set_prio_r7: assert property (@(posedge clk) disable iff (rst) sat_any |=> sat_sticky);
    p_hold_r6: assert property (@(posedge clk) disable iff (rst) (sat_sticky && !sat_clr) |=> sat_sticky);
    p_clear_r6: assert property (@(posedge clk) disable iff (rst) (sat_clr && !sat_any) |=> !sat_sticky);
    p_idle_r10: assert property (@(posedge clk) disable iff (rst) !s1_valid |=> ($stable(result) && !out_valid));
endmodule

bind vec_mhradd_sat smrha_chk #(.VW(VW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .sat_clr    (sat_clr),
    .out_valid  (out_valid),
    .result     (result),
    .sat_sticky (sat_sticky),
    .s1_valid   (s1_valid),
    .sat_any    (sat_any)
);

// File: tb/tb_vec_mhradd_sat.sv
`timescale 1ns/1ps
module tb_vec_mhradd_sat;
    localparam int L = 8;
    localparam int W = 16;
    localparam int VW = L * W;

    logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0, sat_clr = 1'b0;
    logic [VW-1:0] opnd_a = '0, opnd_b = '0, opnd_c = '0;
    logic out_valid, sat_sticky;
    logic [VW-1:0] result;

    int n_tests = 0, n_fail = 0;
    bit model_flag = 1'b0;

    always #2 clk = ~clk;

    vec_mhradd_sat dut (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .opnd_c(opnd_c),
        .sat_clr(sat_clr), .out_valid(out_valid),
        .result(result), .sat_sticky(sat_sticky)
    );

    function automatic logic [15:0] corner(input int k);
        case (k)
            0: return 16'h8000; 1: return 16'h8001; 2: return 16'hC000; 3: return 16'hFFFF;
            4: return 16'h0000; 5: return 16'h0001; 6: return 16'h4000; default: return 16'h7FFF;
        endcase
    endfunction

    function automatic logic [15:0] ref_lane(input logic [15:0] a, input logic [15:0] b,
                                             input logic [15:0] c, output bit clipped);
        longint p, s;
        p = longint'($signed(a)) * longint'($signed(b));
        p = (p + 64'sd16384) >>> 15;
        s = p + longint'($signed(c));
        clipped = (s > 32767) || (s < -32768);
        if (s > 32767)       return 16'h7FFF;
        else if (s < -32768) return 16'h8000;
        else                 return s[15:0];
    endfunction

    function automatic logic [VW-1:0] ref_vec(input logic [VW-1:0] a, input logic [VW-1:0] b,
                                              input logic [VW-1:0] c, output bit any_clip);
        logic [VW-1:0] r;
        bit cl;
        any_clip = 1'b0;
        for (int i = 0; i < L; i++) begin
            r[i*W +: W] = ref_lane(a[i*W +: W], b[i*W +: W], c[i*W +: W], cl);
            any_clip |= cl;
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One vector through the pipe; output checked two edges later
    task automatic run_vec(input logic [VW-1:0] a, input logic [VW-1:0] b,
                           input logic [VW-1:0] c, input string req);
        logic [VW-1:0] exp;
        bit clip;
        exp = ref_vec(a, b, c, clip);
        @(negedge clk);
        opnd_a = a; opnd_b = b; opnd_c = c; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R4 out_valid low after one edge", VW'(out_valid), VW'(0));
        @(negedge clk);
        check("R4 out_valid after two edges", VW'(out_valid), VW'(1));
        check(req, result, exp);
        model_flag = model_flag | clip;
        check("R5 sticky flag", VW'(sat_sticky), VW'(model_flag));
    endtask

    task automatic clear_flag();
        @(negedge clk);
        sat_clr = 1'b1;
        @(negedge clk);
        sat_clr = 1'b0;
        model_flag = 1'b0;
        check("R6 flag cleared", VW'(sat_sticky), VW'(0));
    endtask

    initial begin
        #(4.0 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [VW-1:0] va, vb, vc, hold;
        logic [VW-1:0] sa [3];
        logic [VW-1:0] sb [3];
        logic [VW-1:0] sc [3];
        bit dummy;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        check("R9 out_valid after reset", VW'(out_valid), VW'(0));
        check("R9 result after reset", result, '0);
        check("R9 sticky after reset", VW'(sat_sticky), VW'(0));

        // R8 corner in every lane
        va = {L{16'h8000}}; vb = {L{16'h8000}}; vc = {L{16'h7FFF}};
        run_vec(va, vb, vc, "R8 most-negative squared plus max");
        check("R8 lane value", result, {L{16'h7FFF}});
        check("R8 flag set", VW'(sat_sticky), VW'(1));
        clear_flag();

        // R1 R2 R3 corner sweep: 512 combinations spread over lanes
        for (int v = 0; v < 64; v++) begin
            for (int l = 0; l < L; l++) begin
                int idx;
                idx = v * L + l;
                va[l*W +: W] = corner((idx >> 6) & 7);
                vb[l*W +: W] = corner((idx >> 3) & 7);
                vc[l*W +: W] = corner(idx & 7);
            end
            run_vec(va, vb, vc, "R2 R3 corner sweep");
            clear_flag();
        end

        // R1 lane isolation: one lane clips, neighbours stay small
        va = '0; vb = '0; vc = '0;
        va[3*W +: W] = 16'h7FFF; vb[3*W +: W] = 16'h7FFF; vc[3*W +: W] = 16'h7FFF;
        vc[4*W +: W] = 16'h0005; vc[2*W +: W] = 16'hFFFB;
        run_vec(va, vb, vc, "R1 lane isolation");
        clear_flag();

        // R2 random vectors
        for (int n = 0; n < 1500; n++) begin
            for (int w = 0; w < VW / 32; w++) begin
                va[w*32 +: 32] = $urandom;
                vb[w*32 +: 32] = $urandom;
                vc[w*32 +: 32] = $urandom;
            end
            run_vec(va, vb, vc, "R2 random");
            if (n % 4 == 3) clear_flag();
        end
        clear_flag();

        // R7 clip and clear at the same edge
        va = {L{16'h8000}}; vb = {L{16'h8000}}; vc = {L{16'h7FFF}};
        @(negedge clk);
        opnd_a = va; opnd_b = vb; opnd_c = vc; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; sat_clr = 1'b1;
        @(negedge clk);
        sat_clr = 1'b0;
        check("R7 clip beats clear", VW'(sat_sticky), VW'(1));
        check("R7 result", result, {L{16'h7FFF}});
        // R6 flag held without clear
        repeat (3) @(negedge clk);
        check("R6 flag held", VW'(sat_sticky), VW'(1));
        clear_flag();

        // R10 invalid operands ignored
        hold = result;
        @(negedge clk);
        opnd_a = {L{16'h8000}}; opnd_b = {L{16'h8000}}; opnd_c = {L{16'h7FFF}}; in_valid = 1'b0;
        repeat (3) @(negedge clk);
        check("R10 result unchanged", result, hold);
        check("R10 flag untouched", VW'(sat_sticky), VW'(0));
        check("R10 no out_valid", VW'(out_valid), VW'(0));

        // R4 back-to-back stream of three vectors
        for (int k = 0; k < 3; k++) begin
            for (int w = 0; w < VW / 32; w++) begin
                sa[k][w*32 +: 32] = $urandom;
                sb[k][w*32 +: 32] = $urandom;
                sc[k][w*32 +: 32] = $urandom;
            end
        end
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            if (k >= 2) begin
                check("R4 stream valid", VW'(out_valid), VW'(1));
                check("R4 stream data", result, ref_vec(sa[k-2], sb[k-2], sc[k-2], dummy));
            end
            if (k < 3) begin
                opnd_a = sa[k]; opnd_b = sb[k]; opnd_c = sc[k]; in_valid = 1'b1;
            end else begin
                in_valid = 1'b0;
            end
        end
        @(negedge clk);
        check("R4 stream ends", VW'(out_valid), VW'(0));

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule